// File: doc/BRIEF.md
# Hint-Driven Leaf Clock Gating Controller

This block turns a set of leaf clocks on and off for two kinds of consumer. Peripheral leaves run whenever software has enabled them. Transactional leaves run whenever software hints that they should, or whenever their unit says it is busy. A global clock-enable input and a scan-mode override act on every leaf. Each leaf is derived from its own source clock and has its own active-low asynchronous reset. One transactional unit takes its clock from the slow (divide-by-4) source, and its hint and idle inputs are judged in that domain. The other units use the main source.

Software reaches the block through a one-cycle register port with three registers: peripheral enables, transactional hints, and a read-only status word. The status word shows which transactional leaves are really running, as seen by the per-domain enable flops. Hint and enable bits, the global enable and the idle inputs pass through two-flop synchronizers into each leaf's domain. The run state of each transactional leaf passes back through two flops into the register domain. Every leaf ends in a latch-based gate, so a gated output is either a whole copy of a source high phase or stays low.

Top module: `ccg_gate_ctrl`

## Requirements
- R1: After register reset, address 0 (peripheral enables, bit i = peripheral i) reads all ones, address 1 (hints, bit i = unit i) reads all ones, and address 2 (status, bit i = unit i) reads 0 while `ip_clk_en_i` is low.
- R2: An access with `reg_valid_i` high and `reg_write_i` high updates address 0 or 1. A read returns its data on `reg_rdata_o` after the next rising `clk_i` edge, and `reg_rdata_o` holds its value between reads. Writes to address 2 or 3 change nothing, and address 3 reads 0.
- R3: A transactional leaf runs when (its hint is 1 or its `idle_i` bit is 0) and `ip_clk_en_i` is 1. Otherwise it stops.
- R4: If software clears a unit's hint while that unit's `idle_i` bit is 0, the leaf keeps running and its status bit still reads 1.
- R5: The status bit of a unit is that unit's domain run state. When all units are idle, all hints are set and `ip_clk_en_i` is 1, status reads 3'b111. When a main-domain unit with a clear hint becomes idle, its status bit reads 0 within 8 `clk_i` cycles, given that the main source runs at the register clock.
- R6: Peripheral leaf i runs when its enable bit and `ip_clk_en_i` are both 1. Otherwise it stops.
- R7: Scan mode is active only when `scan_mode_i` equals 4'b0101. Active scan forces every leaf to run. Any other value has no effect.
- R8: While a domain reset is low, the run state of the leaves in that domain is 0 and those leaves stop. Other domains keep running, and the leaves resume after the reset is released.
- R9: The unit at index SLOW_UNIT (default 2) is gated from `clk_slow_i` and judged in that domain. The other units use `clk_main_i`.
- R10: A running leaf passes every source pulse whole. A stopped leaf (with scan off) stays low for the whole source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Register domain reset, active low |
| clk_main_i | input | 1 | Main source clock |
| rst_main_ni | input | 1 | Main domain reset, active low |
| clk_slow_i | input | 1 | Divide-by-4 source clock |
| rst_slow_ni | input | 1 | Slow domain reset, active low |
| clk_peri_i | input | NUM_PERI | Source clock of each peripheral leaf |
| rst_peri_ni | input | NUM_PERI | Reset of each peripheral domain, active low |
| ip_clk_en_i | input | 1 | Global clock enable |
| scan_mode_i | input | 4 | Scan selector, 4'b0101 means active |
| idle_i | input | NUM_TRANS | Per-unit idle flags |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data, valid the cycle after a read |
| clk_peri_o | output | NUM_PERI | Gated peripheral clocks |
| clk_trans_o | output | NUM_TRANS | Gated transactional clocks |

## Verification
A run flop stuck in the wrong state shows up on the gated clock at the very next source high phase: the leaf pulses when it should be quiet, or misses a pulse. The same fault reaches the status word two register cycles later. A synchronizer or decode fault leaves the leaf obeying stale or wrong inputs, and this appears as a status read that disagrees with the formula for the inputs applied some 30 cycles earlier. Edge counts over a window catch partial or missing pulses, and a read at a fixed delay after an idle change catches extra latency on the path that turns a busy unit off.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int SCAN_W = 4;
  localparam logic [SCAN_W-1:0] SCAN_ON = 4'b0101;

  typedef enum logic [1:0] {
    ADDR_PERI = 2'd0,
    ADDR_HINT = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic {
    LEAF_PERI  = 1'b0,
    LEAF_TRANS = 1'b1
  } leaf_kind_e;

  function automatic int reg_width(input int n_peri, input int n_trans);
    return (n_peri > n_trans) ? n_peri : n_trans;
  endfunction

  function automatic logic scan_is_on(input logic [SCAN_W-1:0] mode);
    return mode == SCAN_ON;
  endfunction

  // Run condition of one leaf given its synchronized inputs.
  function automatic logic leaf_want(input leaf_kind_e kind, input logic sw,
                                     input logic idle, input logic ip_en);
    if (kind == LEAF_TRANS) return (sw | ~idle) & ip_en;
    return sw & ip_en;
  endfunction
endpackage

// File: rtl/ccg_sync.sv
module ccg_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/ccg_icg.sv
module ccg_icg (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  // Transparent while the source is low, closed while it is high.
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/ccg_leaf.sv
module ccg_leaf
  import ccg_pkg::*;
#(
  parameter leaf_kind_e KIND = LEAF_PERI
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_i,
  input  logic idle_i,
  input  logic ip_en_i,
  input  logic scan_on_i,
  output logic clk_o,
  output logic run_o
);
  logic [2:0] raw_in, syn_in;
  logic       run_q;
  logic       gate_en;

  assign raw_in = {sw_i, idle_i, ip_en_i};

  ccg_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= leaf_want(KIND, syn_in[2], syn_in[1], syn_in[0]);
  end

  assign gate_en = run_q | scan_on_i;
  assign run_o   = run_q;

  ccg_icg u_icg (
    .clk_i(clk_i),
    .en_i (gate_en),
    .clk_o(clk_o)
  );
endmodule

// File: rtl/ccg_regs.sv
module ccg_regs
  import ccg_pkg::*;
#(
  parameter int NUM_PERI  = 2,
  parameter int NUM_TRANS = 3,
  parameter int REG_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [1:0]           addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_PERI-1:0]  peri_en_o,
  output logic [NUM_TRANS-1:0] hint_o,
  input  logic [NUM_TRANS-1:0] trans_run_i
);
  logic [NUM_PERI-1:0]  peri_q;
  logic [NUM_TRANS-1:0] hint_q;
  logic [NUM_TRANS-1:0] status_s;
  logic [REG_W-1:0]     rd_mux, rdata_q;
  reg_addr_e            addr_e;

  assign addr_e = reg_addr_e'(addr_i);

  ccg_sync #(.W(NUM_TRANS)) u_stat_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trans_run_i),
    .q_o   (status_s)
  );

  always_comb begin
    rd_mux = '0;
    case (addr_e)
      ADDR_PERI: rd_mux[NUM_PERI-1:0]  = peri_q;
      ADDR_HINT: rd_mux[NUM_TRANS-1:0] = hint_q;
      ADDR_STAT: rd_mux[NUM_TRANS-1:0] = status_s;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peri_q  <= '1;
      hint_q  <= '1;
      rdata_q <= '0;
    end else if (valid_i) begin
      if (write_i) begin
        case (addr_e)
          ADDR_PERI: peri_q <= wdata_i[NUM_PERI-1:0];
          ADDR_HINT: hint_q <= wdata_i[NUM_TRANS-1:0];
          default:   ;
        endcase
      end else begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign peri_en_o = peri_q;
  assign hint_o    = hint_q;
endmodule

// File: rtl/ccg_gate_ctrl.sv
module ccg_gate_ctrl
  import ccg_pkg::*;
#(
  parameter int NUM_PERI  = 2,
  parameter int NUM_TRANS = 3,
  parameter int SLOW_UNIT = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clk_main_i,
  input  logic                   rst_main_ni,
  input  logic                   clk_slow_i,
  input  logic                   rst_slow_ni,
  input  logic [NUM_PERI-1:0]    clk_peri_i,
  input  logic [NUM_PERI-1:0]    rst_peri_ni,
  input  logic                   ip_clk_en_i,
  input  logic [SCAN_W-1:0]      scan_mode_i,
  input  logic [NUM_TRANS-1:0]   idle_i,
  input  logic                   reg_valid_i,
  input  logic                   reg_write_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [reg_width(NUM_PERI, NUM_TRANS)-1:0] reg_wdata_i,
  output logic [reg_width(NUM_PERI, NUM_TRANS)-1:0] reg_rdata_o,
  output logic [NUM_PERI-1:0]    clk_peri_o,
  output logic [NUM_TRANS-1:0]   clk_trans_o
);
  localparam int REG_W = reg_width(NUM_PERI, NUM_TRANS);

  // Named internal events, watched by the bound checker.
  logic                 scan_on;
  logic [NUM_PERI-1:0]  peri_sw;
  logic [NUM_TRANS-1:0] hint_sw;
  logic [NUM_PERI-1:0]  peri_run;
  logic [NUM_TRANS-1:0] trans_run;

  assign scan_on = scan_is_on(scan_mode_i);

  ccg_regs #(
    .NUM_PERI (NUM_PERI),
    .NUM_TRANS(NUM_TRANS),
    .REG_W    (REG_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (reg_valid_i),
    .write_i    (reg_write_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .peri_en_o  (peri_sw),
    .hint_o     (hint_sw),
    .trans_run_i(trans_run)
  );

  for (genvar p = 0; p < NUM_PERI; p++) begin : g_peri
    ccg_leaf #(.KIND(LEAF_PERI)) u_leaf (
      .clk_i    (clk_peri_i[p]),
      .rst_ni   (rst_peri_ni[p]),
      .sw_i     (peri_sw[p]),
      .idle_i   (1'b1),
      .ip_en_i  (ip_clk_en_i),
      .scan_on_i(scan_on),
      .clk_o    (clk_peri_o[p]),
      .run_o    (peri_run[p])
    );
  end

  for (genvar t = 0; t < NUM_TRANS; t++) begin : g_trans
    if (t == SLOW_UNIT) begin : g_slow
      ccg_leaf #(.KIND(LEAF_TRANS)) u_leaf (
        .clk_i    (clk_slow_i),
        .rst_ni   (rst_slow_ni),
        .sw_i     (hint_sw[t]),
        .idle_i   (idle_i[t]),
        .ip_en_i  (ip_clk_en_i),
        .scan_on_i(scan_on),
        .clk_o    (clk_trans_o[t]),
        .run_o    (trans_run[t])
      );
    end else begin : g_main
      ccg_leaf #(.KIND(LEAF_TRANS)) u_leaf (
        .clk_i    (clk_main_i),
        .rst_ni   (rst_main_ni),
        .sw_i     (hint_sw[t]),
        .idle_i   (idle_i[t]),
        .ip_en_i  (ip_clk_en_i),
        .scan_on_i(scan_on),
        .clk_o    (clk_trans_o[t]),
        .run_o    (trans_run[t])
      );
    end
  end
endmodule

// File: rtl/ccg_gate_ctrl_chk.sv
module ccg_gate_ctrl_chk #(
  parameter int NUM_PERI  = 2,
  parameter int NUM_TRANS = 3,
  parameter int SLOW_UNIT = 2,
  parameter int REG_W     = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 clk_main_i,
  input logic                 rst_main_ni,
  input logic                 clk_slow_i,
  input logic                 rst_slow_ni,
  input logic [NUM_PERI-1:0]  rst_peri_ni,
  input logic                 ip_clk_en_i,
  input logic                 reg_valid_i,
  input logic                 reg_write_i,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic [NUM_TRANS-1:0] clk_trans_o,
  input logic                 scan_on,
  input logic [NUM_PERI-1:0]  peri_run,
  input logic [NUM_TRANS-1:0] trans_run
);
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_valid_i && !reg_write_i) |-> $stable(reg_rdata_o)); // R2

  for (genvar p = 0; p < NUM_PERI; p++) begin : g_p
    AST_PERI_RESET_STOPS: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !rst_peri_ni[p] |-> !peri_run[p]); // R8
  end

  for (genvar t = 0; t < NUM_TRANS; t++) begin : g_t
    logic dclk, drst;
    logic run_smp, scan_smp;
    if (t == SLOW_UNIT) begin : g_s
      assign dclk = clk_slow_i;
      assign drst = rst_slow_ni;
    end else begin : g_m
      assign dclk = clk_main_i;
      assign drst = rst_main_ni;
      AST_RUN_NEEDS_IPEN: assert property (@(posedge clk_main_i) disable iff (!rst_main_ni)
        trans_run[t] |-> $past(ip_clk_en_i, 3)); // R3
      AST_DOMAIN_RESET_STOPS: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !rst_main_ni |-> !trans_run[t]); // R8
    end

    always_ff @(posedge dclk or negedge drst) begin
      if (!drst) begin
        run_smp  <= 1'b0;
        scan_smp <= 1'b0;
      end else begin
        run_smp  <= trans_run[t];
        scan_smp <= scan_on;
      end
    end

    AST_GATE_PASSES_PULSE: assert property (@(negedge dclk) disable iff (!drst)
      (run_smp || scan_smp) |-> clk_trans_o[t]); // R10
    AST_GATE_QUIET: assert property (@(negedge dclk) disable iff (!drst)
      (!run_smp && !scan_smp) |-> !clk_trans_o[t]); // R10
  end
endmodule

bind ccg_gate_ctrl ccg_gate_ctrl_chk #(
  .NUM_PERI (NUM_PERI),
  .NUM_TRANS(NUM_TRANS),
  .SLOW_UNIT(SLOW_UNIT),
  .REG_W    (REG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_main_i (clk_main_i),
  .rst_main_ni(rst_main_ni),
  .clk_slow_i (clk_slow_i),
  .rst_slow_ni(rst_slow_ni),
  .rst_peri_ni(rst_peri_ni),
  .ip_clk_en_i(ip_clk_en_i),
  .reg_valid_i(reg_valid_i),
  .reg_write_i(reg_write_i),
  .reg_rdata_o(reg_rdata_o),
  .clk_trans_o(clk_trans_o),
  .scan_on    (scan_on),
  .peri_run   (peri_run),
  .trans_run  (trans_run)
);

// File: tb/sim_ccg_gate_ctrl.sv
module sim_ccg_gate_ctrl;
  localparam int NP = 2;
  localparam int NT = 3;
  localparam int RW = 3;

  logic clk_i = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_ni = 1'b1, rst_main_ni = 1'b1, rst_slow_ni = 1'b1;
  logic [NP-1:0] rst_peri_ni = '1;
  logic ip_en = 1'b0;
  logic [3:0] scan = 4'b0000;
  logic [NT-1:0] idle = '1;
  logic valid = 1'b0, write = 1'b0;
  logic [1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic [NP-1:0] clk_peri_o;
  logic [NT-1:0] clk_trans_o;

  always #10 clk_i = ~clk_i;
  initial begin
    #5;
    forever #40 clk_slow = ~clk_slow;
  end

  ccg_gate_ctrl u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_main_i (clk_i),
    .rst_main_ni(rst_main_ni),
    .clk_slow_i (clk_slow),
    .rst_slow_ni(rst_slow_ni),
    .clk_peri_i ({clk_slow, clk_i}),
    .rst_peri_ni(rst_peri_ni),
    .ip_clk_en_i(ip_en),
    .scan_mode_i(scan),
    .idle_i     (idle),
    .reg_valid_i(valid),
    .reg_write_i(write),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .clk_peri_o (clk_peri_o),
    .clk_trans_o(clk_trans_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Edge counters on the gated outputs.
  int cnt_t0 = 0, cnt_t1 = 0, cnt_t2 = 0, cnt_p0 = 0, cnt_p1 = 0;
  always @(posedge clk_trans_o[0]) cnt_t0++;
  always @(posedge clk_trans_o[1]) cnt_t1++;
  always @(posedge clk_trans_o[2]) cnt_t2++;
  always @(posedge clk_peri_o[0])  cnt_p0++;
  always @(posedge clk_peri_o[1])  cnt_p1++;

  function automatic int sel_cnt(input int which);
    case (which)
      0: return cnt_t0;
      1: return cnt_t1;
      2: return cnt_t2;
      3: return cnt_p0;
      default: return cnt_p1;
    endcase
  endfunction

  // Scoreboard for register reads.
  logic [RW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_pend = 1'b0;
  logic [RW-1:0] last_rd = '0;

  always @(posedge clk_i) rd_pend <= valid && !write;

  always @(negedge clk_i) begin
    if (rd_pend) begin
      logic [RW-1:0] e;
      string tg;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected read data", int'(rdata), 0);
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(rdata === e, tg, int'(rdata), int'(e));
      end
      last_rd = rdata;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    @(negedge clk_i);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk_i);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [RW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk_i);
    valid = 1'b0;
    cyc(1);
  endtask

  // which: 0..2 units, 3..4 peripherals; exp_edges < 0 means "running, slow source".
  task automatic leaf_edges(input int which, input int exp_edges, input string tag);
    int c0, d;
    c0 = sel_cnt(which);
    cyc(32);
    d = sel_cnt(which) - c0;
    if (exp_edges < 0) check(d >= 7 && d <= 9, tag, d, 8);
    else               check(d == exp_edges, tag, d, exp_edges);
  endtask

  initial begin
    #1;
    rst_ni = 1'b0; rst_main_ni = 1'b0; rst_slow_ni = 1'b0; rst_peri_ni = '0;
    cyc(5);
    rst_ni = 1'b1; rst_main_ni = 1'b1; rst_slow_ni = 1'b1; rst_peri_ni = '1;
    cyc(4);

    rd(2'd0, 3'b011, "R1 peri enable reset value");
    rd(2'd1, 3'b111, "R1 hint reset value");
    rd(2'd2, 3'b000, "R1 status with global enable low");
    leaf_edges(0, 0, "R3 unit0 stopped while global enable low");

    ip_en = 1'b1;
    cyc(30);
    rd(2'd2, 3'b111, "R5 all hints all idle status");
    leaf_edges(0, 32, "R10 unit0 passes every pulse");
    leaf_edges(2, -1, "R9 slow unit runs on slow source");
    leaf_edges(3, 32, "R6 peri0 runs when enabled");

    wr(2'd1, 3'b000);
    cyc(30);
    rd(2'd1, 3'b000, "R2 hint write readback");
    rd(2'd2, 3'b000, "R3 hints clear and idle gives status 0");
    leaf_edges(1, 0, "R3 unit1 stopped");

    idle[0] = 1'b0;
    cyc(30);
    rd(2'd2, 3'b001, "R4 busy unit keeps status 1 with hint clear");
    leaf_edges(0, 32, "R4 busy unit clock runs");
    idle[0] = 1'b1;
    cyc(6);
    rd(2'd2, 3'b000, "R5 status drops within 8 cycles of idle");

    wr(2'd0, 3'b010);
    cyc(30);
    rd(2'd0, 3'b010, "R6 peri enable readback");
    leaf_edges(3, 0, "R6 peri0 stopped when disabled");
    leaf_edges(4, -1, "R6 peri1 still enabled");

    ip_en = 1'b0;
    scan = 4'b1010;
    cyc(30);
    leaf_edges(0, 0, "R7 non-On scan value has no effect");
    scan = 4'b0101;
    cyc(4);
    leaf_edges(0, 32, "R7 scan On forces unit0");
    leaf_edges(3, 32, "R7 scan On forces disabled peri0");
    scan = 4'b0000;
    ip_en = 1'b1;

    wr(2'd1, 3'b111);
    cyc(30);
    rst_main_ni = 1'b0;
    cyc(10);
    leaf_edges(0, 0, "R8 main-domain unit stopped in reset");
    leaf_edges(2, -1, "R8 slow unit unaffected by main reset");
    rd(2'd2, 3'b100, "R8 status during main reset");
    rst_main_ni = 1'b1;
    cyc(30);
    rd(2'd2, 3'b111, "R8 status after main reset release");

    wr(2'd2, 3'b000);
    rd(2'd2, 3'b111, "R2 status write ignored");
    wr(2'd3, 3'b111);
    rd(2'd3, 3'b000, "R2 unused address reads 0");
    rd(2'd0, 3'b010, "R2 unused address write ignored");
    cyc(4);
    check(rdata === last_rd, "R2 read data held between reads", int'(rdata), int'(last_rd));

    cyc(2);
    check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 64'd150000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule